// File: doc/BRIEF.md
# Flash Write-Protection Range Decoder

This unit sits inside a serial NOR flash model, beside the program and erase paths. Each time a program or erase request arrives, it takes the currently latched status byte and works out which contiguous address window is write-protected. It then reports whether the request's 24-bit target address falls inside that window.

The window is not read from a stored table. Its length comes from the three-bit protect level in the status byte. By default that level selects a power-of-two share of the array, scaled to the array size fixed at elaboration. A sector-mode bit instead selects a few fixed small lengths. A direction bit places the window at the bottom or the top of the array. An invert bit swaps the window for its complement, which always sits against the opposite end.

The result is registered. It appears together with a one-cycle valid pulse in the cycle after the request strobe, and it holds until the next request.

Top module: `bp_range_decoder`

## Requirements
- R1: The status byte is decoded as protect level L = bits [2:0], direction D = bit 3, sector mode S = bit 4 and invert I = bit 5; bits 7:6 are ignored. L = 000 with I = 0 gives an empty window, whatever S and D are.
- R2: L = 111 with I = 0 protects the whole array, from 0 to size−1, whatever S and D are.
- R3: With S = 0 and 1 ≤ L ≤ 6, the protected length is G·2^(L−1) bytes, where G = max(64 kB, size/64). The length is capped at the full array.
- R4: For arrays smaller than 512 kB with S = 0, L = 100 gives an empty window, and L = 101 and 110 give the same lengths as 001 and 010.
- R5: With D = 0 the window ends at the last array address. With D = 1 it starts at address 0.
- R6: With S = 1, L = 001, 010 and 011 give 4, 8 and 16 kB. L = 100, 101 and 110 all give 32 kB, or 64 kB when parameter LARGE_TOP_SECT is 1.
- R7: With I = 1 the window is the rest of the array outside the window that I = 0 would give, placed against the opposite end. A full window inverts to empty, and an empty one inverts to full.
- R8: An empty window is reported by rng_none = 1, with rng_start = rng_last = 0 and rsp_blocked = 0.
- R9: rsp_blocked is 1 exactly when rng_none = 0 and rng_start ≤ address ≤ rng_last.
- R10: Outputs update one clock after req_valid is high, and rsp_valid pulses for that one cycle. While req_valid is low, the status and address inputs are ignored and all range outputs hold.
- R11: After reset, rsp_valid = 0, rsp_blocked = 0, rng_none = 1 and rng_start = rng_last = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Program/erase check request strobe |
| prot_status | input | 8 | Latched status byte holding the protect fields |
| req_addr | input | 24 | Target byte address of the request |
| rsp_valid | output | 1 | One-cycle pulse marking a fresh result |
| rsp_blocked | output | 1 | Target address lies in the protected window |
| rng_none | output | 1 | Protected window is empty |
| rng_start | output | 24 | First protected address |
| rng_last | output | 24 | Last protected address |

## Verification
The bench builds three instances that share the same stimulus:
- A 1 MB array with 32 kB top sectors, on which the small-sector bottom example can be checked directly.
- A 256 kB array, which reaches the wrap-around of the upper protect levels.
- An 8 MB array with 64 kB top sectors, where the granule scales to size/64 and the large-sector option is active.

Together these cover both granule regimes, both small-sector limits and the small-array exception. Addresses are drawn close to the window edges so that off-by-one errors in start, end and the invert arithmetic show up in the blocked flag.

// File: rtl/bp_pkg.sv
package bp_pkg;
    localparam int unsigned ADDR_W = 24;
    localparam int unsigned LEN_W  = ADDR_W + 1;

    typedef struct packed {
        logic [1:0] unused;
        logic       inv;
        logic       sect;
        logic       dir;
        logic [2:0] level;
    } prot_bits_t;

    typedef struct packed {
        logic              valid;
        logic              blocked;
        logic              none;
        logic [ADDR_W-1:0] start;
        logic [ADDR_W-1:0] last;
    } rsp_state_t;
endpackage

// File: rtl/bp_len_calc.sv
module bp_len_calc
    import bp_pkg::*;
#(
    parameter int unsigned SIZE_KB        = 1024,
    parameter bit          LARGE_TOP_SECT = 1'b0
) (
    input  logic [2:0]       level,
    input  logic             sect,
    output logic [LEN_W-1:0] len
);
    localparam logic [31:0] ARRAY_B  = 32'(SIZE_KB) * 32'd1024;
    localparam int unsigned GRAN_KB  = (SIZE_KB >= 4096) ? (SIZE_KB / 64) : 64;
    localparam logic [31:0] GRAN_B   = 32'(GRAN_KB) * 32'd1024;
    localparam logic [31:0] TOP_SECT = LARGE_TOP_SECT ? 32'd65536 : 32'd32768;
    localparam bit          WRAP     = (SIZE_KB < 512);

    logic [2:0]  lvl_eff;
    logic [31:0] scaled;
    logic [31:0] len_w;

    generate
        if (WRAP) begin : g_wrap
            always_comb lvl_eff = level[2] ? {1'b0, level[1:0]} : level;
        end else begin : g_nowrap
            always_comb lvl_eff = level;
        end
    endgenerate

    always_comb begin
        scaled = 32'd0;
        if (lvl_eff != 3'd0) begin
            scaled = GRAN_B << (lvl_eff - 3'd1);
        end
        if (scaled > ARRAY_B) begin
            scaled = ARRAY_B;
        end

        if (level == 3'd0) begin
            len_w = 32'd0;
        end else if (level == 3'd7) begin
            len_w = ARRAY_B;
        end else if (sect) begin
            case (level)
                3'd1:    len_w = 32'd4096;
                3'd2:    len_w = 32'd8192;
                3'd3:    len_w = 32'd16384;
                default: len_w = TOP_SECT;
            endcase
        end else begin
            len_w = scaled;
        end
    end

    assign len = len_w[LEN_W-1:0];
endmodule

// File: rtl/bp_range_map.sv
module bp_range_map
    import bp_pkg::*;
#(
    parameter int unsigned SIZE_KB = 1024
) (
    input  logic [LEN_W-1:0]  len,
    input  logic              dir,
    input  logic              inv,
    output logic              none,
    output logic [ADDR_W-1:0] start,
    output logic [ADDR_W-1:0] last
);
    localparam logic [31:0]      ARRAY_B32 = 32'(SIZE_KB) * 32'd1024;
    localparam logic [LEN_W-1:0] ARRAY_B   = ARRAY_B32[LEN_W-1:0];

    logic [LEN_W-1:0] eff_len;
    logic             at_top;
    logic [LEN_W-1:0] lo_w;
    logic [LEN_W-1:0] hi_w;

    always_comb begin
        eff_len = inv ? (ARRAY_B - len) : len;
        at_top  = inv ? dir : ~dir;
        none    = (eff_len == '0);
        lo_w    = '0;
        hi_w    = '0;
        if (!none) begin
            if (at_top) begin
                lo_w = ARRAY_B - eff_len;
                hi_w = ARRAY_B - 1'b1;
            end else begin
                lo_w = '0;
                hi_w = eff_len - 1'b1;
            end
        end
        start = lo_w[ADDR_W-1:0];
        last  = hi_w[ADDR_W-1:0];
    end
endmodule

// File: rtl/bp_range_decoder.sv
module bp_range_decoder
    import bp_pkg::*;
#(
    parameter int unsigned SIZE_KB        = 1024,
    parameter bit          LARGE_TOP_SECT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [7:0]        prot_status,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_blocked,
    output logic              rng_none,
    output logic [ADDR_W-1:0] rng_start,
    output logic [ADDR_W-1:0] rng_last
);
    localparam rsp_state_t ST_RST = '{valid: 1'b0, blocked: 1'b0, none: 1'b1,
                                      start: '0, last: '0};

    prot_bits_t        pb;
    logic [LEN_W-1:0]  base_len;
    logic              win_none;
    logic [ADDR_W-1:0] win_start;
    logic [ADDR_W-1:0] win_last;
    rsp_state_t        st_d;
    rsp_state_t        st_q;

    assign pb = prot_bits_t'(prot_status);

    bp_len_calc #(
        .SIZE_KB       (SIZE_KB),
        .LARGE_TOP_SECT(LARGE_TOP_SECT)
    ) u_len (
        .level(pb.level),
        .sect (pb.sect),
        .len  (base_len)
    );

    bp_range_map #(
        .SIZE_KB(SIZE_KB)
    ) u_map (
        .len  (base_len),
        .dir  (pb.dir),
        .inv  (pb.inv),
        .none (win_none),
        .start(win_start),
        .last (win_last)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (req_valid) begin
            st_d.valid   = 1'b1;
            st_d.none    = win_none;
            st_d.start   = win_start;
            st_d.last    = win_last;
            st_d.blocked = !win_none && (req_addr >= win_start) && (req_addr <= win_last);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid   = st_q.valid;
    assign rsp_blocked = st_q.blocked;
    assign rng_none    = st_q.none;
    assign rng_start   = st_q.start;
    assign rng_last    = st_q.last;
endmodule

// File: rtl/bp_range_checker.sv
module bp_range_checker
    import bp_pkg::*;
#(
    parameter int unsigned SIZE_KB = 1024
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [7:0]        prot_status,
    input logic              rsp_valid,
    input logic              rsp_blocked,
    input logic              rng_none,
    input logic [ADDR_W-1:0] rng_start,
    input logic [ADDR_W-1:0] rng_last
);
    localparam logic [31:0]       LAST32   = 32'(SIZE_KB) * 32'd1024 - 32'd1;
    localparam logic [ADDR_W-1:0] LAST_ADR = LAST32[ADDR_W-1:0];

    p_valid_on_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_valid_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(rng_start) && $stable(rng_last)
                        && $stable(rng_none) && $stable(rsp_blocked)));

    p_level_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && prot_status[2:0] == 3'd0 && !prot_status[5]) |=> rng_none);

    p_level_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && prot_status[2:0] == 3'd7 && !prot_status[5])
        |=> (!rng_none && rng_start == '0 && rng_last == LAST_ADR));

    p_anchor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rng_none |-> (rng_start == '0 || rng_last == LAST_ADR));

    p_none_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rng_none |-> (!rsp_blocked && rng_start == '0 && rng_last == '0));

    p_ordered_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rng_none |-> (rng_start <= rng_last));
endmodule

bind bp_range_decoder bp_range_checker #(.SIZE_KB(SIZE_KB)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .prot_status(prot_status),
    .rsp_valid  (rsp_valid),
    .rsp_blocked(rsp_blocked),
    .rng_none   (rng_none),
    .rng_start  (rng_start),
    .rng_last   (rng_last)
);

// File: tb/sim_bp_range_decoder.sv
module sim_bp_range_decoder;
    localparam int CLK_P = 10;
    localparam int KB0 = 1024, KB1 = 256, KB2 = 8192;
    localparam bit BG0 = 1'b0, BG1 = 1'b0, BG2 = 1'b1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  prot_status = 8'h00;
    logic [23:0] req_addr = 24'h0;

    logic        v0, v1, v2, b0, b1, b2, n0, n1, n2;
    logic [23:0] s0, s1, s2, l0, l1, l2;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    bp_range_decoder #(.SIZE_KB(KB0), .LARGE_TOP_SECT(BG0)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .prot_status(prot_status),
        .req_addr(req_addr), .rsp_valid(v0), .rsp_blocked(b0), .rng_none(n0),
        .rng_start(s0), .rng_last(l0));
    bp_range_decoder #(.SIZE_KB(KB1), .LARGE_TOP_SECT(BG1)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .prot_status(prot_status),
        .req_addr(req_addr), .rsp_valid(v1), .rsp_blocked(b1), .rng_none(n1),
        .rng_start(s1), .rng_last(l1));
    bp_range_decoder #(.SIZE_KB(KB2), .LARGE_TOP_SECT(BG2)) u2 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .prot_status(prot_status),
        .req_addr(req_addr), .rsp_valid(v2), .rsp_blocked(b2), .rng_none(n2),
        .rng_start(s2), .rng_last(l2));

    // Length in bytes of the window before inversion (R1, R2, R3, R4, R6).
    function automatic int model_len(int kb, bit big, logic [2:0] lv, logic sc);
        int arr = kb * 1024;
        int b;
        int l;
        if (lv == 3'd0) return 0;
        if (lv == 3'd7) return arr;
        if (sc) begin
            case (lv)
                3'd1: return 4096;
                3'd2: return 8192;
                3'd3: return 16384;
                default: return big ? 65536 : 32768;
            endcase
        end
        b = lv;
        if (kb < 512 && lv >= 3'd4) begin
            if (lv == 3'd4) return 0;
            b = lv - 4;
        end
        if (kb >= 4096) l = arr >> (7 - b);
        else l = 65536 << (b - 1);
        if (l > arr) l = arr;
        return l;
    endfunction

    // Expected window: packed {none, start, last} (R5, R7, R8).
    function automatic logic [48:0] model_win(int kb, bit big, logic [7:0] st);
        int arr = kb * 1024;
        int l = model_len(kb, big, st[2:0], st[4]);
        bit top = ~st[3];
        if (st[5]) begin
            l = arr - l;
            top = ~top;
        end
        if (l == 0) return {1'b1, 24'd0, 24'd0};
        if (top) return {1'b0, 24'(arr - l), 24'(arr - 1)};
        return {1'b0, 24'd0, 24'(l - 1)};
    endfunction

    function automatic string tag_of(int kb, logic [7:0] st);
        if (st[5]) return "R7";
        if (st[2:0] == 3'd0) return "R1";
        if (st[2:0] == 3'd7) return "R2";
        if (st[4]) return "R6";
        if (kb < 512 && st[2]) return "R4";
        if (st[3]) return "R5";
        return "R3";
    endfunction

    task automatic chk_dut(string who, int kb, bit big, logic [7:0] st, logic [23:0] ad,
                           bit exp_v, logic av, logic ab, logic an, logic [23:0] as_,
                           logic [23:0] al, string force_tag);
        logic [48:0] w = model_win(kb, big, st);
        logic eb = !w[48] && ad >= w[47:24] && ad <= w[23:0];
        string t = (force_tag != "") ? force_tag : tag_of(kb, st);
        n_chk++;
        if (av !== exp_v || an !== w[48] || as_ !== w[47:24] || al !== w[23:0]) begin
            n_fail++;
            $display("FAIL %s %s st=%h: got v=%b none=%b %h..%h exp v=%b none=%b %h..%h",
                     t, who, st, av, an, as_, al, exp_v, w[48], w[47:24], w[23:0]);
        end
        n_chk++;
        if (ab !== eb) begin
            n_fail++;
            $display("FAIL R9 %s st=%h addr=%h: got blocked=%b exp %b", who, st, ad, ab, eb);
        end
    endtask

    task automatic run_req(logic [7:0] st, logic [23:0] ad);
        @(negedge clk);
        req_valid   = 1'b1;
        prot_status = st;
        req_addr    = ad;
        @(negedge clk);
        chk_dut("u0", KB0, BG0, st, ad, 1'b1, v0, b0, n0, s0, l0, "");
        chk_dut("u1", KB1, BG1, st, ad, 1'b1, v1, b1, n1, s1, l1, "");
        chk_dut("u2", KB2, BG2, st, ad, 1'b1, v2, b2, n2, s2, l2, "");
        req_valid   = 1'b0;
        prot_status = 8'($urandom);
        req_addr    = 24'($urandom);
        @(negedge clk);
        // R10: idle cycle with changed inputs leaves results untouched
        chk_dut("u0", KB0, BG0, st, ad, 1'b0, v0, b0, n0, s0, l0, "R10");
        chk_dut("u1", KB1, BG1, st, ad, 1'b0, v1, b1, n1, s1, l1, "R10");
        chk_dut("u2", KB2, BG2, st, ad, 1'b0, v2, b2, n2, s2, l2, "R10");
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [48:0] w;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R11: reset state
        n_chk++;
        if (v0 !== 1'b0 || b0 !== 1'b0 || n0 !== 1'b1 || s0 !== 24'd0 || l0 !== 24'd0) begin
            n_fail++;
            $display("FAIL R11 u0: got v=%b b=%b none=%b %h..%h exp 0 0 1 0..0", v0, b0, n0, s0, l0);
        end
        rst_n = 1'b1;

        // R6 small-sector bottom 32 kB on 1 MB: expect 0..7FFF
        run_req(8'h1C, 24'h007FFF);
        run_req(8'h1C, 24'h008000);
        // R5 bottom window, level 2
        run_req(8'h0A, 24'h01FFFF);
        // R3 top window, level 2
        run_req(8'h02, 24'h7FFFFF);
        // R1 / R2 with don't-care sector and direction bits, plus ignored bits 7:6
        run_req(8'hD8, 24'h000000);
        run_req(8'hDF, 24'h000000);
        // R4 wrap levels on small array
        for (int lv = 4; lv < 7; lv++) run_req(8'(lv), 24'h03FFFF);
        // R7 inversions, including full and empty cases
        run_req(8'h20, 24'h000000);
        run_req(8'h27, 24'h000000);
        run_req(8'h22, 24'h0FFFFF);
        run_req(8'h3D, 24'h000000);
        // R6 large top sector option on u2
        run_req(8'h16, 24'h7F0000);

        for (int i = 0; i < 400; i++) begin
            logic [7:0]  st = {2'($urandom), 6'($urandom)};
            logic [23:0] ad;
            int sel = $urandom_range(0, 5);
            w = model_win(KB0, BG0, st);
            case (sel)
                0: ad = w[47:24];
                1: ad = w[47:24] - 24'd1;
                2: ad = w[23:0];
                3: ad = w[23:0] + 24'd1;
                default: ad = 24'($urandom);
            endcase
            run_req(st, ad);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule